// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits beside the command decoder of a synchronous DRAM core. It turns one column command into the column address of every data beat that follows. A mode word, loaded beforehand, selects the burst length, the ordering of the beats, the read latency and whether writes are shortened to one beat. Each start strobe carries a starting column and a read/write flag. From the next cycle the block presents one column per cycle, together with a valid flag, a flag on the final beat and the direction of the burst.

A burst ends after its programmed number of beats. It also ends on a stop request, or when a new start replaces it. A full-page burst walks the whole row and wraps around it until it is stopped. When the clock-enable input is low, nothing moves: the address, the beat position, the flags and the mode word all hold. The data array and the read-data latency pipeline live elsewhere. The latency value is only passed out for the neighbouring logic.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, no beat is valid, the last flag is low and the configuration is length 1, sequential, writes at full length, latency 1 (`cas_lat` = 1).
- R2: Mode word bits [2:0] select the length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. Bit 3 selects the order (0 sequential, 1 interleaved). Bits [6:4] give the latency, which appears on `cas_lat` (001 gives 1, 010 gives 2, 011 gives 3).
- R3: A mode load is ignored as a whole, and the previous configuration stays, when any of these holds: length code 100, 101 or 110; full page combined with interleaved order; latency code 000 or 1xx; bits [8:7] not 00.
- R4: In sequential order, beat i carries (start + i) mod L inside the L-aligned block that holds the start column, and the bits above that block are unchanged.
- R5: In interleaved order, beat i carries the start column with its low log2(L) bits XORed with i.
- R6: When mode bit 9 is 1, every write burst is a single beat, while reads keep the programmed length.
- R7: The first beat appears in the cycle after the start strobe is taken. Valid stays high for exactly L beats, the last flag marks the final beat only, and valid is low in the cycle after it.
- R8: A full-page burst counts sequentially over 2^COL_W columns, wraps from the top column to 0, and never raises the last flag.
- R9: A start taken during a burst restarts it at once: the next cycle shows beat 0 of the new burst.
- R10: A stop request taken without a start clears valid in the next cycle.
- R11: While `cke` is sampled low, the column, the beat position, all flags and the configuration hold from the next cycle on. Start, stop and mode loads at those edges are ignored.
- R12: `beat_wr` shows the read/write flag of the start that began the current burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes all state |
| mode_load | input | 1 | Load strobe for the mode word |
| mode_word | input | 10 | Mode fields: length [2:0], order [3], latency [6:4], op mode [8:7], single write [9] |
| start | input | 1 | Column command strobe |
| start_col | input | COL_W | Starting column of the burst |
| start_wr | input | 1 | 1 for a write burst, 0 for a read |
| stop | input | 1 | Burst stop request |
| col_out | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is present this cycle |
| beat_last | output | 1 | The current beat is the final one |
| beat_wr | output | 1 | Direction of the current burst |
| cas_lat | output | 2 | Programmed read latency (1 to 3) |

## Verification
A wrong internal state almost always shows up at the ports within one beat. A bad block mask or a wrong order bit changes `col_out` on the second beat of a burst. A wrong beat counter or length moves `beat_last`, or leaves `beat_valid` high for one cycle too many. A configuration that took a reserved word shows up as a changed `cas_lat` in the cycle after the load. It also shows up as a different beat count in the next burst. A freeze that leaks shows up as `col_out` moving in the first cycle after `cke` falls.

// File: rtl/burst_col_pkg.sv
// Shared types and field codes for the burst column generator.
// Assumes the mode word bit layout documented in the brief.
package burst_col_pkg;

    localparam int MODE_W = 10;

    // Burst length codes of mode word bits [2:0]
    localparam logic [2:0] BLEN_1    = 3'b000;
    localparam logic [2:0] BLEN_2    = 3'b001;
    localparam logic [2:0] BLEN_4    = 3'b010;
    localparam logic [2:0] BLEN_8    = 3'b011;
    localparam logic [2:0] BLEN_PAGE = 3'b111;

    // Decoded, accepted configuration
    typedef struct packed {
        logic       wr_single;
        logic [1:0] latency;
        logic       interleave;
        logic [2:0] blen;
    } mode_t;

    localparam mode_t MODE_RESET = '{wr_single: 1'b0, latency: 2'd1,
                                     interleave: 1'b0, blen: BLEN_1};

endpackage

// File: rtl/burst_mode_reg.sv
// Mode register: checks a loaded word and keeps the last legal configuration.
// Assumes a load is only honoured on an edge where cke is high.
module burst_mode_reg
    import burst_col_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output mode_t             mode
);

    mode_t decoded;
    logic  len_ok;
    logic  combo_ok;
    logic  lat_ok;
    logic  op_ok;
    logic  word_ok;

    // Split the word into fields and judge its legality
    always_comb begin
        decoded.blen       = word[2:0];
        decoded.interleave = word[3];
        decoded.latency    = word[5:4];
        decoded.wr_single  = word[9];
        len_ok   = (word[2] == 1'b0) || (word[2:0] == BLEN_PAGE);
        combo_ok = !((word[2:0] == BLEN_PAGE) && word[3]);
        lat_ok   = (word[6] == 1'b0) && (word[5:4] != 2'b00);
        op_ok    = (word[8:7] == 2'b00);
        word_ok  = len_ok && combo_ok && lat_ok && op_ok;
    end

    // Store an accepted word; reserved words leave the register alone
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_RESET;
        end else if (cke && load && word_ok) begin
            mode <= decoded;
        end
    end

    // R3
    reserved_load_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !word_ok) |=> $stable(mode));

    // R11
    frozen_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke) |=> $stable(mode));

    // R2
    latency_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode.latency != 2'd0);

endmodule

// File: rtl/burst_beat_seq.sv
// Beat sequencer: captures a burst at start, counts its beats and flags the last.
// Assumes COL_W >= 3 so an eight-beat block fits in the column range.
module burst_beat_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             start_wr,
    input  logic             stop,
    input  logic [2:0]       blen,
    input  logic             interleave,
    input  logic             wr_single,
    output logic             active,
    output logic             last,
    output logic             wr,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] idx,
    output logic [COL_W-1:0] mask,
    output logic             order_xor
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic             page_q;
    logic             shorten;
    logic             start_page;
    logic [1:0]       shift;
    logic [COL_W-1:0] start_mask;

    // Work out the window of the burst about to start
    always_comb begin
        shorten    = start_wr && wr_single;
        start_page = (blen == BLEN_PAGE) && !shorten;
        shift      = shorten ? 2'd0 : blen[1:0];
        start_mask = start_page ? '1 : ((ONE << shift) - ONE);
    end

    // Final beat: index reached the top of a bounded window
    always_comb begin
        last = active && !page_q && (idx == mask);
    end

    // Capture on start, end on stop or last beat, otherwise advance; cke low holds all
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            page_q    <= 1'b0;
            wr        <= 1'b0;
            order_xor <= 1'b0;
            base      <= '0;
            idx       <= '0;
            mask      <= '0;
        end else if (cke) begin
            if (start) begin
                active    <= 1'b1;
                page_q    <= start_page;
                wr        <= start_wr;
                order_xor <= interleave && !start_page;
                base      <= start_col;
                idx       <= '0;
                mask      <= start_mask;
            end else if (stop) begin
                active <= 1'b0;
            end else if (active) begin
                if (last) begin
                    active <= 1'b0;
                end else begin
                    idx <= idx + ONE;
                end
            end
        end
    end

    // R7
    idx_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ((idx & ~mask) == '0));

    // R7
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && last && !start) |=> !active);

    // R8
    page_runs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && active && page_q && !start && !stop) |=> active);

endmodule

// File: rtl/burst_addr_map.sv
// Address mapper: forms the beat column from base, beat index and window mask.
// Assumes mask is a run of ones from bit 0 and idx never leaves that window.
module burst_addr_map #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             order_xor,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] sum;

    // Sequential candidate; carries past the window are dropped bit by bit below
    always_comb begin
        sum = base + idx;
    end

    // Per bit: inside the window pick the ordered value, outside keep the base
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = mask[i] ? (order_xor ? (base[i] ^ idx[i]) : sum[i]) : base[i];
    end

endmodule

// File: rtl/burst_col_gen.sv
// Top of the burst column generator: mode register, beat sequencer and mapper.
// Assumes start and stop are one-cycle strobes from the command decoder.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              start_wr,
    input  logic              stop,
    output logic [COL_W-1:0]  col_out,
    output logic              beat_valid,
    output logic              beat_last,
    output logic              beat_wr,
    output logic [1:0]        cas_lat
);

    mode_t            mode;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] idx;
    logic [COL_W-1:0] mask;
    logic             order_xor;

    burst_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .load  (mode_load),
        .word  (mode_word),
        .mode  (mode)
    );

    burst_beat_seq #(.COL_W(COL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .start      (start),
        .start_col  (start_col),
        .start_wr   (start_wr),
        .stop       (stop),
        .blen       (mode.blen),
        .interleave (mode.interleave),
        .wr_single  (mode.wr_single),
        .active     (beat_valid),
        .last       (beat_last),
        .wr         (beat_wr),
        .base       (base),
        .idx        (idx),
        .mask       (mask),
        .order_xor  (order_xor)
    );

    burst_addr_map #(.COL_W(COL_W)) u_map (
        .base      (base),
        .idx       (idx),
        .mask      (mask),
        .order_xor (order_xor),
        .col       (col_out)
    );

    // Latency is passed straight to the read-data pipeline
    always_comb begin
        cas_lat = mode.latency;
    end

    // R9
    restart_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && start) |=> (beat_valid && (col_out == $past(start_col))));

    // R10
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && stop && !start) |=> !beat_valid);

    // R11
    freeze_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke) |=> ($stable(col_out) && $stable(beat_valid) && $stable(beat_last)));

    // R12
    direction_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && start) |=> (beat_wr == $past(start_wr)));

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

endmodule

// File: tb/burst_col_gen_test.sv
// Bench: a vector table walked by one loop, then directed corner tests.
module burst_col_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       mode_load = 1'b0;
    logic [9:0] mode_word = '0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic       start_wr = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] col_out;
    logic       beat_valid;
    logic       beat_last;
    logic       beat_wr;
    logic [1:0] cas_lat;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    burst_col_gen #(.COL_W(9)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .mode_load  (mode_load),
        .mode_word  (mode_word),
        .start      (start),
        .start_col  (start_col),
        .start_wr   (start_wr),
        .stop       (stop),
        .col_out    (col_out),
        .beat_valid (beat_valid),
        .beat_last  (beat_last),
        .beat_wr    (beat_wr),
        .cas_lat    (cas_lat)
    );

    typedef struct packed {
        logic [3:0]      req;
        logic [9:0]      mode;
        logic [1:0]      lat;
        logic [8:0]      col;
        logic            wr;
        logic [3:0]      len;
        logic [0:7][8:0] seq;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd4, 10'h033, 2'd3, 9'd5,   1'b0, 4'd8, '{9'd5, 9'd6, 9'd7, 9'd0, 9'd1, 9'd2, 9'd3, 9'd4}},
        '{4'd5, 10'h03B, 2'd3, 9'd5,   1'b0, 4'd8, '{9'd5, 9'd4, 9'd7, 9'd6, 9'd1, 9'd0, 9'd3, 9'd2}},
        '{4'd4, 10'h032, 2'd3, 9'd14,  1'b0, 4'd4, '{9'd14, 9'd15, 9'd12, 9'd13, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{4'd5, 10'h03A, 2'd3, 9'd503, 1'b1, 4'd4, '{9'd503, 9'd502, 9'd501, 9'd500, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{4'd2, 10'h021, 2'd2, 9'd257, 1'b0, 4'd2, '{9'd257, 9'd256, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{4'd2, 10'h010, 2'd1, 9'd170, 1'b1, 4'd1, '{9'd170, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{4'd6, 10'h233, 2'd3, 9'd19,  1'b1, 4'd1, '{9'd19, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}},
        '{4'd6, 10'h233, 2'd3, 9'd19,  1'b0, 4'd8, '{9'd19, 9'd20, 9'd21, 9'd22, 9'd23, 9'd16, 9'd17, 9'd18}},
        '{4'd5, 10'h03B, 2'd3, 9'd510, 1'b0, 4'd8, '{9'd510, 9'd511, 9'd508, 9'd509, 9'd506, 9'd507, 9'd504, 9'd505}},
        '{4'd5, 10'h039, 2'd3, 9'd68,  1'b0, 4'd2, '{9'd68, 9'd69, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0}}
    };

    // Count one check; report a mismatch with actual and expected values
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_mode(input logic [9:0] w);
        mode_load = 1'b1;
        mode_word = w;
        tick();
        mode_load = 1'b0;
    endtask

    // After return, beat 0 of the new burst is on the outputs
    task automatic launch(input logic [8:0] c, input logic w);
        start     = 1'b1;
        start_col = c;
        start_wr  = w;
        tick();
        start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state and reset configuration
        chk("R1 valid", beat_valid, 0);
        chk("R1 last", beat_last, 0);
        chk("R1 latency", cas_lat, 1);
        launch(9'd7, 1'b0);
        chk("R1 single beat col", col_out, 7);
        chk("R1 single beat last", beat_last, 1);
        tick();
        chk("R1 ends after one", beat_valid, 0);

        // Table walk: R2 R4 R5 R6 R7 R12
        for (int v = 0; v < NV; v++) begin
            load_mode(VECS[v].mode);
            chk($sformatf("R%0d vec%0d latency", VECS[v].req, v), cas_lat, VECS[v].lat);
            launch(VECS[v].col, VECS[v].wr);
            for (int b = 0; b < int'(VECS[v].len); b++) begin
                chk($sformatf("R%0d vec%0d beat%0d col", VECS[v].req, v, b), col_out, VECS[v].seq[b]);
                chk($sformatf("R7 vec%0d beat%0d valid", v, b), beat_valid, 1);
                chk($sformatf("R7 vec%0d beat%0d last", v, b), beat_last,
                    (b == int'(VECS[v].len) - 1) ? 1 : 0);
                chk($sformatf("R12 vec%0d beat%0d dir", v, b), beat_wr, VECS[v].wr);
                tick();
            end
            chk($sformatf("R7 vec%0d valid drops", v), beat_valid, 0);
        end

        // R3 reserved words leave the configuration unchanged
        load_mode(10'h033);
        load_mode(10'h034);
        load_mode(10'h003);
        load_mode(10'h043);
        load_mode(10'h03F);
        load_mode(10'h0B3);
        chk("R3 latency kept", cas_lat, 3);
        launch(9'd0, 1'b0);
        for (int b = 0; b < 8; b++) begin
            chk($sformatf("R3 beat%0d col", b), col_out, b);
            chk($sformatf("R3 beat%0d last", b), beat_last, (b == 7) ? 1 : 0);
            tick();
        end
        chk("R3 eight beats only", beat_valid, 0);

        // R8 full page wrap, then R10 stop
        load_mode(10'h037);
        launch(9'd510, 1'b0);
        for (int b = 0; b < 512; b++) begin
            if (b < 4) begin
                chk($sformatf("R8 beat%0d col", b), col_out, (510 + b) % 512);
                chk($sformatf("R8 beat%0d no last", b), beat_last, 0);
            end
            tick();
        end
        chk("R8 full wrap col", col_out, 510);
        chk("R8 still valid", beat_valid, 1);
        stop = 1'b1;
        tick();
        stop = 1'b0;
        chk("R10 page stopped", beat_valid, 0);

        // R9 restart mid-burst
        load_mode(10'h033);
        launch(9'd8, 1'b0);
        chk("R9 beat0", col_out, 8);
        tick();
        chk("R9 beat1", col_out, 9);
        tick();
        chk("R9 beat2", col_out, 10);
        launch(9'd44, 1'b1);
        for (int b = 0; b < 8; b++) begin
            chk($sformatf("R9 new beat%0d col", b), col_out, 40 + ((4 + b) % 8));
            chk($sformatf("R9 new beat%0d last", b), beat_last, (b == 7) ? 1 : 0);
            chk($sformatf("R12 new beat%0d dir", b), beat_wr, 1);
            tick();
        end
        chk("R9 new burst ends", beat_valid, 0);

        // R10 stop mid-burst and while idle
        launch(9'd0, 1'b0);
        tick();
        chk("R10 beat1", col_out, 1);
        stop = 1'b1;
        tick();
        chk("R10 valid cleared", beat_valid, 0);
        chk("R10 last cleared", beat_last, 0);
        tick();
        stop = 1'b0;
        chk("R10 idle stop", beat_valid, 0);

        // R11 freeze; start and mode load at frozen edges are ignored
        load_mode(10'h032);
        launch(9'd20, 1'b0);
        tick();
        chk("R11 before freeze", col_out, 21);
        cke       = 1'b0;
        start     = 1'b1;
        start_col = 9'd100;
        mode_load = 1'b1;
        mode_word = 10'h021;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk($sformatf("R11 frozen col %0d", k), col_out, 21);
            chk($sformatf("R11 frozen valid %0d", k), beat_valid, 1);
        end
        cke       = 1'b1;
        start     = 1'b0;
        mode_load = 1'b0;
        tick();
        chk("R11 resume col", col_out, 22);
        chk("R11 mode not loaded", cas_lat, 3);
        tick();
        chk("R11 resume last col", col_out, 23);
        chk("R11 resume last", beat_last, 1);
        tick();
        chk("R11 ends", beat_valid, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule